// File: doc/BRIEF.md
# Micro-operation sequenced control unit

This block is a small accumulator processor. Every instruction is carried out as a short, fixed series of register transfers between an address register, a data buffer register, a program counter, an instruction register and one general register. A 2-bit phase code tracks where the processor is in the instruction cycle: reading the instruction word, following an indirect pointer, carrying out the operation, or entering an interrupt. A step counter times the transfers within each phase. The processor moves from phase to phase on its own and needs no outside control beyond reset.

It talks to one synchronous memory port. Read data comes back exactly one clock after the address is presented. A write takes effect on the clock edge where the write strobe is high. The port has no back-pressure, so the memory must accept every write and answer every read with that fixed latency. A level-sensitive interrupt request is taken only when the processor's own enable flag is set. A halt output reports that the processor has stopped.

Top module: `useq_cpu`

## Requirements
- R1: While `rst` is high, `halt` and `mem_we` are low. After reset the first instruction is read from address `RESET_PC`, which is on `mem_addr` one cycle after reset is released.
- R2: The phase code is 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. Fetch is followed by indirect when the word's bit 15 is set, and by execute otherwise. Indirect is always followed by execute. Execute is followed by interrupt or by fetch. Interrupt is always followed by fetch.
- R3: An instruction word holds an indirect flag in bit 15, an opcode in bits 14:12 and an address in bits 11:0. Fetch takes four cycles: the address register takes PC; a wait cycle holds the address; the buffer takes the read data while PC advances by one; the instruction register takes the buffer.
- R4: LOAD (opcode 1) copies the word at the operand address into R1. ADD (opcode 2) adds that word to R1 modulo 2^16. Each takes four execute cycles, and the operand address is on `mem_addr` one cycle after execute begins.
- R5: STORE (opcode 3) writes R1 to the operand address. The write strobe is high for exactly one cycle, the second cycle of execute.
- R6: When bit 15 is set, the address field is replaced by the low 12 bits of the word stored at that address before execute. This holds for every opcode that uses an address.
- R7: BSA (opcode 4) with operand X writes the address of the following instruction to X, and execution continues at X+1.
- R8: An interrupt is entered at the end of an execute phase when `irq` is high and the enable flag is set. Entry writes PC to `SAVE_ADDR`, clears the enable flag and continues at `ISR_ADDR`, whose address is on `mem_addr` two cycles after the save write. EI (opcode 5) sets the flag, and it first counts at the end of the next instruction. While the flag is clear, `irq` has no effect.
- R9: HALT (opcode 7) raises `halt`. From then on, until reset, there are no writes and `mem_addr` does not change.
- R10: Opcodes 0 and 6 change no register other than PC and take one execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request, level |
| mem_addr | output | ADDR_W (12) | Memory address, driven from the address register |
| mem_wdata | output | ADDR_W+4 (16) | Write data, driven from the buffer register |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | ADDR_W+4 (16) | Read data, valid one cycle after the address |
| halt | output | 1 | High once HALT has executed |

## Verification
Internal state shows up mainly through the address bus and the write stream. A wrong step count or a wrong phase choice moves every later address and write by whole cycles, so it is caught by the cycle-stamped checks on the first operand address, the first store and the fetch after interrupt entry. A wrong R1, PC or indirect pointer shows up as soon as the next STORE, BSA or interrupt save writes a value, and the scoreboard compares each write in order. An interrupt taken too early or taken twice adds a write to the save address, and that breaks the ordered write list at once.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int STEP_W = 2;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_IND   = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  typedef enum logic [2:0] {
    OP_NOP0  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ADD   = 3'd2,
    OP_STORE = 3'd3,
    OP_BSA   = 3'd4,
    OP_EI    = 3'd5,
    OP_NOP6  = 3'd6,
    OP_HALT  = 3'd7
  } op_e;

  // index of the final timed step for a phase (and opcode in execute)
  function automatic logic [STEP_W-1:0] final_step(phase_e ph, op_e op);
    logic [STEP_W-1:0] s;
    s = '0;
    case (ph)
      PH_FETCH: s = 2'd3;
      PH_IND:   s = 2'd3;
      PH_INTR:  s = 2'd2;
      default: begin
        case (op)
          OP_LOAD, OP_ADD: s = 2'd3;
          OP_BSA:          s = 2'd2;
          OP_STORE:        s = 2'd1;
          default:         s = 2'd0;
        endcase
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/useq_add.sv
module useq_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  assign y = a + b;
endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic              ind_flag,
  input  logic              irq,
  input  logic              ien,
  output phase_e            phase,
  output logic [STEP_W-1:0] step,
  output logic              last,
  output logic              take_intr,
  output logic              halt
);

  phase_e            ph_n;
  logic [STEP_W-1:0] st_n;
  logic              halt_n;
  logic              stop_now;

  always_comb begin
    last      = (step == final_step(phase, op));
    stop_now  = (phase == PH_EXEC) && (op == OP_HALT);
    take_intr = (phase == PH_EXEC) && last && !stop_now && irq && ien;
    ph_n      = phase;
    st_n      = step;
    halt_n    = halt;
    if (halt || stop_now) begin
      halt_n = 1'b1;
    end else if (!last) begin
      st_n = step + 2'd1;
    end else begin
      st_n = '0;
      case (phase)
        PH_FETCH: ph_n = ind_flag ? PH_IND : PH_EXEC;
        PH_IND:   ph_n = PH_EXEC;
        PH_EXEC:  ph_n = take_intr ? PH_INTR : PH_FETCH;
        default:  ph_n = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      step  <= '0;
      halt  <= 1'b0;
    end else begin
      phase <= ph_n;
      step  <= st_n;
      halt  <= halt_n;
    end
  end

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && $stable(phase) && $stable(step)));

  p_ind_to_exec_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IND && last) |=> (phase == PH_EXEC && step == '0));

  p_fetch_exit_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && last) |=> ((phase == PH_IND || phase == PH_EXEC) && step == '0));

endmodule

// File: rtl/useq_dp.sv
module useq_dp
  import useq_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned RESET_PC  = 32'h020,
  parameter int unsigned SAVE_ADDR = 32'h010,
  parameter int unsigned ISR_ADDR  = 32'h011
) (
  input  logic                clk,
  input  logic                rst,
  input  phase_e              phase,
  input  logic [STEP_W-1:0]   step,
  input  logic                take_intr,
  input  logic [ADDR_W+3:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [ADDR_W+3:0]   mem_wdata,
  output logic                mem_we,
  output op_e                 op,
  output logic                ind_flag,
  output logic                ien
);

  localparam int WORD_W = ADDR_W + 4;
  localparam int IR_W   = WORD_W - 1;

  logic [ADDR_W-1:0] mar_q;
  logic [WORD_W-1:0] mbr_q;
  logic [ADDR_W-1:0] pc_q;
  logic [IR_W-1:0]   ir_q;
  logic [WORD_W-1:0] r1_q;
  logic [WORD_W-1:0] sum;
  logic [ADDR_W-1:0] ir_addr;
  logic [WORD_W-1:0] pc_word;

  assign op       = op_e'(ir_q[IR_W-1 -: 3]);
  assign ir_addr  = ir_q[ADDR_W-1:0];
  assign ind_flag = mbr_q[WORD_W-1];
  assign pc_word  = {{(WORD_W-ADDR_W){1'b0}}, pc_q};

  useq_add #(.W(WORD_W)) u_add (
    .a (r1_q),
    .b (mbr_q),
    .y (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
      mbr_q <= '0;
      pc_q  <= ADDR_W'(RESET_PC);
      ir_q  <= '0;
      r1_q  <= '0;
      ien   <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: begin
          case (step)
            2'd0: mar_q <= pc_q;
            2'd2: begin
              mbr_q <= mem_rdata;
              pc_q  <= pc_q + ADDR_W'(1);
            end
            2'd3: ir_q <= mbr_q[IR_W-1:0];
            default: ;
          endcase
        end
        PH_IND: begin
          case (step)
            2'd0: mar_q <= ir_addr;
            2'd2: mbr_q <= mem_rdata;
            2'd3: ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
            default: ;
          endcase
        end
        PH_EXEC: begin
          case (op)
            OP_LOAD, OP_ADD: begin
              case (step)
                2'd0: mar_q <= ir_addr;
                2'd2: mbr_q <= mem_rdata;
                2'd3: r1_q  <= (op == OP_ADD) ? sum : mbr_q;
                default: ;
              endcase
            end
            OP_STORE: begin
              if (step == 2'd0) begin
                mar_q <= ir_addr;
                mbr_q <= r1_q;
              end
            end
            OP_BSA: begin
              case (step)
                2'd0: begin
                  mar_q <= ir_addr;
                  mbr_q <= pc_word;
                end
                2'd1: pc_q <= ir_addr;
                2'd2: pc_q <= pc_q + ADDR_W'(1);
                default: ;
              endcase
            end
            OP_EI: ien <= 1'b1;
            default: ;
          endcase
        end
        default: begin
          case (step)
            2'd0: mbr_q <= pc_word;
            2'd1: begin
              mar_q <= ADDR_W'(SAVE_ADDR);
              pc_q  <= ADDR_W'(ISR_ADDR);
            end
            default: ;
          endcase
        end
      endcase
      if (take_intr) ien <= 1'b0;
    end
  end

  always_comb begin
    mem_we = 1'b0;
    if (phase == PH_EXEC && (op == OP_STORE || op == OP_BSA) && step == 2'd1)
      mem_we = 1'b1;
    if (phase == PH_INTR && step == 2'd2)
      mem_we = 1'b1;
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;

  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_intr_ien_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INTR) |-> !ien);

  p_ir_hold_exec_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && $past(phase) == PH_EXEC) |-> $stable(ir_q));

endmodule

// File: rtl/useq_cpu.sv
module useq_cpu
  import useq_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned RESET_PC  = 32'h020,
  parameter int unsigned SAVE_ADDR = 32'h010,
  parameter int unsigned ISR_ADDR  = 32'h011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W+3:0] mem_wdata,
  output logic              mem_we,
  input  logic [ADDR_W+3:0] mem_rdata,
  output logic              halt
);

  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic              last;
  logic              take_intr;
  op_e               op;
  logic              ind_flag;
  logic              ien;

  useq_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .ind_flag  (ind_flag),
    .irq       (irq),
    .ien       (ien),
    .phase     (phase),
    .step      (step),
    .last      (last),
    .take_intr (take_intr),
    .halt      (halt)
  );

  useq_dp #(
    .ADDR_W    (ADDR_W),
    .RESET_PC  (RESET_PC),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .step      (step),
    .take_intr (take_intr),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .op        (op),
    .ind_flag  (ind_flag),
    .ien       (ien)
  );

endmodule

// File: tb/tb_useq_cpu.sv
module tb_useq_cpu;

  logic        clk = 1'b0;
  logic        rst;
  logic        irq;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        halt;

  int tests = 0;
  int fails = 0;
  int n = 0;
  int nwrites = 0;
  int w_save = -100;
  bit done = 1'b0;
  bit first_wr = 1'b1;

  logic [15:0] mem [0:1023];
  logic [27:0] exp_q [$];
  string       tag_q [$];

  always #2.5ns clk = ~clk;

  useq_cpu dut (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halt      (halt)
  );

  // memory model: one-cycle read latency, write at the edge
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expect_wr(input logic [11:0] a, input logic [15:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // monitor: timing probes and write scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (n == 1) chk(mem_addr == 12'h020, "R1 first fetch address", 32'(mem_addr), 32'h020);
      if (n == 2) chk(mem_addr == 12'h020, "R3 wait step holds address", 32'(mem_addr), 32'h020);
      if (n == 5) chk(mem_addr == 12'h100, "R4 operand address timing", 32'(mem_addr), 32'h100);
      if (n == w_save + 2) chk(mem_addr == 12'h011, "R8 handler fetch address", 32'(mem_addr), 32'h011);
      if (mem_we) begin
        nwrites++;
        if (first_wr) begin
          chk(n == 21, "R5 first store cycle", 32'(n), 32'd21);
          first_wr = 1'b0;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'h0);
        end else begin
          logic [27:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({mem_addr, mem_wdata} == e, t, {4'h0, mem_addr, mem_wdata}, {4'h0, e});
          if (mem_addr == 12'h010) w_save = n;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    // program at 0x020
    mem[10'h020] = 16'h1100; // LOAD 100
    mem[10'h021] = 16'h2101; // ADD 101
    mem[10'h022] = 16'h3200; // STORE 200
    mem[10'h023] = 16'hA102; // ADD @102
    mem[10'h024] = 16'hB104; // STORE @104
    mem[10'h025] = 16'h4300; // BSA 300
    mem[10'h301] = 16'h1105; // LOAD 105
    mem[10'h302] = 16'h2106; // ADD 106
    mem[10'h303] = 16'h3202; // STORE 202
    mem[10'h304] = 16'h5000; // EI
    mem[10'h305] = 16'h0000; // opcode 0
    mem[10'h011] = 16'h3203; // handler: STORE 203
    mem[10'h012] = 16'h7000; // HALT
    mem[10'h100] = 16'h0005;
    mem[10'h101] = 16'h0007;
    mem[10'h102] = 16'h0103;
    mem[10'h103] = 16'h0010;
    mem[10'h104] = 16'h0201;
    mem[10'h105] = 16'hFFFF;
    mem[10'h106] = 16'h0002;

    expect_wr(12'h200, 16'h000C, "R4 load+add then store");
    expect_wr(12'h201, 16'h001C, "R6 indirect add and store");
    expect_wr(12'h300, 16'h0026, "R7 return address save");
    expect_wr(12'h202, 16'h0001, "R4 add wraps after jump to X+1");
    expect_wr(12'h010, 16'h0306, "R8 R10 interrupt saves PC");
    expect_wr(12'h203, 16'h0001, "R8 handler store, no re-entry");

    rst = 1'b1;
    irq = 1'b1; // held high: must be ignored until enabled
    repeat (3) @(negedge clk);
    chk(halt == 1'b0, "R1 halt low in reset", 32'(halt), 32'd0);
    chk(mem_we == 1'b0, "R1 no write in reset", 32'(mem_we), 32'd0);
    rst = 1'b0;

    while (!halt && !done) @(negedge clk);
    if (!done) begin
      logic [11:0] a0;
      chk(halt == 1'b1, "R9 halt raised", 32'(halt), 32'd1);
      a0 = mem_addr;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        chk(halt && !mem_we && mem_addr == a0, "R9 stopped",
            {halt, mem_we, 18'h0, mem_addr}, {2'b10, 18'h0, a0});
      end
      chk(nwrites == 6 && exp_q.size() == 0, "R8 R2 write count", 32'(nwrites), 32'd6);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL R9 watchdog expired actual=running expected=halted");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule